// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-source state for a bank of interrupt inputs and decides when each source is offered to a single downstream presentation stage. Each table entry stores a destination server, a current priority, a saved priority and four status flags: asserted, sent, rejected and pending-while-masked. Whether an entry is level or message type is fixed when the block is built. A priority of all ones marks the entry as masked. The global interrupt number of an entry is its table index plus a fixed base.

Message sources raise an event on a rising input edge. The event is offered at once if the entry is unmasked. If the entry is masked, the event is held until a later unmask. Level sources are offered while the input is high and the entry is not already marked sent. The presentation stage sends back rejects and end-of-interrupt notices. It can also ask for a resend sweep, which walks the table one entry per clock. A small configuration port sets, disables, enables and reads back entries and reports parameter errors.

All offers go out through one valid/ready request port. When several entries are waiting, the lowest index goes first. Waiting offers are kept per entry until the request is accepted.

Top module: `irq_source_ctl`

## Requirements
- R1: After reset every entry reads back priority 0xFF and server 0, and no request is offered.
- R2: A rising input edge on an unmasked message entry offers a request carrying base plus index and the entry's priority. The request stays valid until pres_ready is seen high.
- R3: A rising edge on a masked message entry is held as pending-while-masked. A later configuration that unmasks the entry offers it and clears the pending flag.
- R4: A level entry is offered only when its priority is not 0xFF, it is asserted and it is not sent. Offering sets sent, so a level entry that stays high is offered only once.
- R5: A reject for a global number sets that entry's rejected flag and clears its sent flag. No new offer follows until a resend sweep.
- R6: An end-of-interrupt clears sent on a level entry, so the next sweep offers it again while it is still asserted.
- R7: A resend sweep applies the level rule to level entries. For a message entry with rejected set, it clears rejected and offers the entry only if the priority is not 0xFF. A second sweep does not offer it again.
- R8: Configuration operation codes are SET=0, OFF=1, ON=2 and GET=3. SET stores server, priority and saved priority. GET returns server and priority on rd_server and rd_prio. cfg_ack pulses one cycle after cfg_valid.
- R9: OFF writes priority 0xFF and saves the previous priority. ON restores the priority from the saved value.
- R10: A global number outside [base, base+count) raises cfg_err and changes nothing, for every operation. So does a SET whose server is not below the server count.
- R11: When several entries wait together, the one with the lowest index is offered first, whatever the priorities.
- R12: The sweep visits one entry per clock and holds its position while a request is valid and not accepted.
- R13: A configuration write re-applies the level rule, so an asserted level entry that was masked is offered when it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Source inputs: a level for level entries, a rising edge as the event for message entries |
| cfg_valid | input | 1 | Configuration operation strobe |
| cfg_op | input | 2 | Operation: SET=0, OFF=1, ON=2, GET=3 |
| cfg_num | input | NUM_W | Global interrupt number addressed |
| cfg_server | input | SRV_W | Server for SET |
| cfg_prio | input | PRIO_W | Priority for SET |
| cfg_ack | output | 1 | Pulses one cycle after cfg_valid |
| cfg_err | output | 1 | Parameter error flag, valid with cfg_ack |
| rd_server | output | SRV_W | Server returned by GET |
| rd_prio | output | PRIO_W | Priority returned by GET |
| rej_valid | input | 1 | Reject notice strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Starts a resend sweep |
| scan_busy | output | 1 | A sweep is in progress |
| pres_valid | output | 1 | A request is offered |
| pres_ready | input | 1 | The presentation stage accepts the request |
| pres_num | output | NUM_W | Global number of the offered source |
| pres_prio | output | PRIO_W | Priority of the offered source |

## Verification
The hardest state to reach is a sweep that stalls in the middle of the table. This needs a rejected message entry below an asserted level entry whose sent flag was cleared by a reject, with the presentation stage holding ready low. The stimulus builds that state from directed rejects and then accepts the first request by hand. It then checks that the sweep picks up where it stopped and offers the level entry next. Random configuration traffic, including out-of-range numbers and servers, is checked against a bench model through GET readback.

// File: rtl/irq_src_pkg.sv
// Shared types for the interrupt source state controller.
package irq_src_pkg;
    typedef enum logic [1:0] {
        CFG_SET = 2'd0,
        CFG_OFF = 2'd1,
        CFG_ON  = 2'd2,
        CFG_GET = 2'd3
    } cfg_op_e;

    typedef struct packed {
        logic asserted;
        logic sent;
        logic rejected;
        logic mpend;
    } src_status_t;
endpackage

// File: rtl/irq_src_entry.sv
// One table entry: holds server, priority, saved priority and status, and
// raises 'fire' when the entry wants to be offered. Assumes every hit input
// is already decoded to this entry and that src_in is synchronous to clk.
module irq_src_entry
    import irq_src_pkg::*;
#(
    parameter int PRIO_W   = 8,
    parameter int SRV_W    = 4,
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_in,
    input  logic              rej_hit,
    input  logic              eoi_hit,
    input  logic              cfg_hit,
    input  cfg_op_e           cfg_op,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              scan_hit,
    input  logic              grant,
    output logic [SRV_W-1:0]  server,
    output logic [PRIO_W-1:0] prio,
    output logic              fire
);
    localparam logic [PRIO_W-1:0] MASKED = '1;

    logic [SRV_W-1:0]  srv_q, srv_n;
    logic [PRIO_W-1:0] prio_q, prio_n, saved_q, saved_n;
    src_status_t       st_q, st_n;
    logic              fire_q, fire_n, src_q, eval;

    // Next-state: apply grant, reject, EOI, input, config and sweep in order.
    always_comb begin
        srv_n   = srv_q;
        prio_n  = prio_q;
        saved_n = saved_q;
        st_n    = st_q;
        fire_n  = fire_q;
        eval    = 1'b0;
        if (grant) fire_n = 1'b0;
        if (rej_hit) begin
            st_n.rejected = 1'b1;
            st_n.sent     = 1'b0;
        end
        if (eoi_hit && IS_LEVEL) st_n.sent = 1'b0;
        if (IS_LEVEL) begin
            if (src_in != src_q) begin
                st_n.asserted = src_in;
                eval          = 1'b1;
            end
        end else if (src_in && !src_q) begin
            if (prio_q == MASKED) st_n.mpend = 1'b1;
            else                  fire_n     = 1'b1;
        end
        if (cfg_hit && cfg_op != CFG_GET) begin
            case (cfg_op)
                CFG_SET: begin
                    srv_n   = cfg_server;
                    prio_n  = cfg_prio;
                    saved_n = cfg_prio;
                end
                CFG_OFF: begin
                    prio_n  = MASKED;
                    saved_n = prio_q;
                end
                CFG_ON:  prio_n = saved_q;
                default: ;
            endcase
            if (prio_n == MASKED) begin
                if (fire_n) begin
                    fire_n = 1'b0;
                    if (IS_LEVEL) st_n.sent  = 1'b0;
                    else          st_n.mpend = 1'b1;
                end
            end else if (!IS_LEVEL && st_n.mpend) begin
                st_n.mpend = 1'b0;
                fire_n     = 1'b1;
            end
            if (IS_LEVEL) eval = 1'b1;
        end
        if (scan_hit) begin
            if (IS_LEVEL) eval = 1'b1;
            else if (st_n.rejected) begin
                st_n.rejected = 1'b0;
                if (prio_n != MASKED) fire_n = 1'b1;
            end
        end
        if (eval && IS_LEVEL && prio_n != MASKED && st_n.asserted && !st_n.sent) begin
            st_n.sent = 1'b1;
            fire_n    = 1'b1;
        end
    end

    // State registers; reset masks the entry and clears its status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srv_q   <= '0;
            prio_q  <= MASKED;
            saved_q <= MASKED;
            st_q    <= '0;
            fire_q  <= 1'b0;
            src_q   <= 1'b0;
        end else begin
            srv_q   <= srv_n;
            prio_q  <= prio_n;
            saved_q <= saved_n;
            st_q    <= st_n;
            fire_q  <= fire_n;
            src_q   <= src_in;
        end
    end

    assign server = srv_q;
    assign prio   = prio_q;
    assign fire   = fire_q;

    // R9: a masked entry never waits to be offered.
    a_r9_masked_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_q == MASKED) |-> !fire_q);
    // R3: the pending-while-masked flag only lives on a masked entry.
    a_r3_mpend_masked: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mpend |-> (prio_q == MASKED));

    generate
        if (IS_LEVEL) begin : g_lvl_chk
            // R4: sent only rises on an asserted level entry.
            a_r4_sent_asserted: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.sent) |-> st_q.asserted);
        end else begin : g_msg_chk
            // R4: message entries never use the sent flag.
            a_r4_msg_no_sent: assert property (@(posedge clk) disable iff (!rst_n)
                !st_q.sent);
        end
    endgenerate
endmodule

// File: rtl/irq_src_pick.sv
// Picks the lowest-index waiting entry and returns a one-hot grant when the
// request is accepted. Assumes N >= 2.
module irq_src_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     fire,
    input  logic             ready,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);
    // Priority encoder: the lowest set index wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (fire[i]) idx = IDX_W'(i);
        end
    end

    assign valid = |fire;

    // Grant decode for the accepted entry.
    always_comb begin
        grant = '0;
        if (valid && ready) grant[idx] = 1'b1;
    end
endmodule

// File: rtl/irq_src_scan.sv
// Resend sweep: walks the table one index per clock and holds its position
// while 'stall' is high. A start request during a sweep is ignored.
module irq_src_scan #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stall,
    output logic             busy,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    assign hit = busy && !stall;

    // Sweep position and activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (!busy) begin
            busy <= start;
            idx  <= '0;
        end else if (!stall) begin
            if (idx == LAST) busy <= 1'b0;
            else             idx  <= idx + 1'b1;
        end
    end

    // R12: the sweep holds its place while a request waits.
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stall) |=> $stable(idx));
    // R12: one entry per clock when not stalled.
    a_r12_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && idx != LAST) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/irq_source_ctl.sv
// Interrupt source state controller top. It decodes the configuration,
// reject and EOI numbers against the base, builds one entry per source and
// drives a single valid/ready request port. Assumes one presentation stage.
module irq_source_ctl
    import irq_src_pkg::*;
#(
    parameter int                 NUM_SRC    = 8,
    parameter int                 BASE       = 16,
    parameter int                 NUM_SRV    = 4,
    parameter int                 SRV_W      = 4,
    parameter int                 PRIO_W     = 8,
    parameter int                 NUM_W      = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               cfg_valid,
    input  logic [1:0]         cfg_op,
    input  logic [NUM_W-1:0]   cfg_num,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [PRIO_W-1:0]  cfg_prio,
    output logic               cfg_ack,
    output logic               cfg_err,
    output logic [SRV_W-1:0]   rd_server,
    output logic [PRIO_W-1:0]  rd_prio,
    input  logic               rej_valid,
    input  logic [NUM_W-1:0]   rej_num,
    input  logic               eoi_valid,
    input  logic [NUM_W-1:0]   eoi_num,
    input  logic               resend_req,
    output logic               scan_busy,
    output logic               pres_valid,
    input  logic               pres_ready,
    output logic [NUM_W-1:0]   pres_num,
    output logic [PRIO_W-1:0]  pres_prio
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [NUM_W-1:0] BASE_N = NUM_W'(BASE);

    cfg_op_e           op;
    logic              cfg_in_rng, srv_ok, cfg_bad;
    logic              rej_in_rng, eoi_in_rng;
    logic [IDX_W-1:0]  cfg_idx, rej_idx, eoi_idx, pick_idx, scan_idx;
    logic              scan_hit;
    logic [NUM_SRC-1:0] fire_v, grant_v;
    logic [SRV_W-1:0]  srv_a  [NUM_SRC];
    logic [PRIO_W-1:0] prio_a [NUM_SRC];

    assign op = cfg_op_e'(cfg_op);

    // Range checks and index extraction for the three numbered inputs.
    assign cfg_in_rng = (int'(cfg_num) >= BASE) && (int'(cfg_num) < BASE + NUM_SRC);
    assign rej_in_rng = (int'(rej_num) >= BASE) && (int'(rej_num) < BASE + NUM_SRC);
    assign eoi_in_rng = (int'(eoi_num) >= BASE) && (int'(eoi_num) < BASE + NUM_SRC);
    assign srv_ok     = int'(cfg_server) < NUM_SRV;
    assign cfg_bad    = !cfg_in_rng || (op == CFG_SET && !srv_ok);
    assign cfg_idx    = IDX_W'(cfg_num - BASE_N);
    assign rej_idx    = IDX_W'(rej_num - BASE_N);
    assign eoi_idx    = IDX_W'(eoi_num - BASE_N);

    irq_src_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .fire  (fire_v),
        .ready (pres_ready),
        .valid (pres_valid),
        .idx   (pick_idx),
        .grant (grant_v)
    );

    irq_src_scan #(.N(NUM_SRC), .IDX_W(IDX_W)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .start (resend_req),
        .stall (pres_valid && !pres_ready),
        .busy  (scan_busy),
        .hit   (scan_hit),
        .idx   (scan_idx)
    );

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
            irq_src_entry #(
                .PRIO_W   (PRIO_W),
                .SRV_W    (SRV_W),
                .IS_LEVEL (LEVEL_MASK[g])
            ) u_ent (
                .clk        (clk),
                .rst_n      (rst_n),
                .src_in     (src_in[g]),
                .rej_hit    (rej_valid && rej_in_rng && rej_idx == IDX_W'(g)),
                .eoi_hit    (eoi_valid && eoi_in_rng && eoi_idx == IDX_W'(g)),
                .cfg_hit    (cfg_valid && !cfg_bad && cfg_idx == IDX_W'(g)),
                .cfg_op     (op),
                .cfg_server (cfg_server),
                .cfg_prio   (cfg_prio),
                .scan_hit   (scan_hit && scan_idx == IDX_W'(g)),
                .grant      (grant_v[g]),
                .server     (srv_a[g]),
                .prio       (prio_a[g]),
                .fire       (fire_v[g])
            );
        end
    endgenerate

    assign pres_num  = BASE_N + NUM_W'(pick_idx);
    assign pres_prio = prio_a[pick_idx];

    // Configuration response: acknowledge, error flag and GET readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_ack   <= 1'b0;
            cfg_err   <= 1'b0;
            rd_server <= '0;
            rd_prio   <= '0;
        end else begin
            cfg_ack <= cfg_valid;
            if (cfg_valid) begin
                cfg_err <= cfg_bad;
                if (op == CFG_GET && !cfg_bad) begin
                    rd_server <= srv_a[cfg_idx];
                    rd_prio   <= prio_a[cfg_idx];
                end
            end
        end
    end

    // R8: every operation is acknowledged on the next cycle.
    a_r8_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_ack);
    // R2: an offered number always lies inside the table's range.
    a_r2_num_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid |-> (int'(pres_num) >= BASE && int'(pres_num) < BASE + NUM_SRC));
endmodule

// File: tb/tb_irq_source_ctl.sv
module tb_irq_source_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_in = '0;
    logic       cfg_valid = 1'b0;
    logic [1:0] cfg_op = '0;
    logic [7:0] cfg_num = '0;
    logic [3:0] cfg_server = '0;
    logic [7:0] cfg_prio = '0;
    logic       cfg_ack, cfg_err;
    logic [3:0] rd_server;
    logic [7:0] rd_prio;
    logic       rej_valid = 1'b0;
    logic [7:0] rej_num = '0;
    logic       eoi_valid = 1'b0;
    logic [7:0] eoi_num = '0;
    logic       resend_req = 1'b0;
    logic       scan_busy, pres_valid;
    logic       pres_ready = 1'b0;
    logic [7:0] pres_num, pres_prio;

    int n_chk = 0;
    int n_fail = 0;
    int m_prio [8];
    int m_saved [8];
    int m_srv [8];

    always #5 clk = ~clk;

    irq_source_ctl dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_num(cfg_num),
        .cfg_server(cfg_server), .cfg_prio(cfg_prio),
        .cfg_ack(cfg_ack), .cfg_err(cfg_err), .rd_server(rd_server), .rd_prio(rd_prio),
        .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend_req(resend_req), .scan_busy(scan_busy),
        .pres_valid(pres_valid), .pres_ready(pres_ready),
        .pres_num(pres_num), .pres_prio(pres_prio)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_err(input int op, input int num, input int srv);
        return (num < 16) || (num > 23) || (op == 0 && srv >= 4);
    endfunction

    task automatic cfg(input int op, input int num, input int srv, input int prio);
        cfg_valid = 1'b1; cfg_op = 2'(op); cfg_num = 8'(num);
        cfg_server = 4'(srv); cfg_prio = 8'(prio);
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic get_chk(input string tag, input int num, input int srv, input int prio);
        cfg(3, num, 0, 0);
        chk({tag, " err"}, cfg_err, 0);
        chk({tag, " prio"}, rd_prio, prio);
        chk({tag, " server"}, rd_server, srv);
    endtask

    task automatic pulse(input int i);
        src_in[i] = 1'b1; @(negedge clk);
        src_in[i] = 1'b0; @(negedge clk);
    endtask

    task automatic take();
        pres_ready = 1'b1; @(negedge clk); pres_ready = 1'b0;
    endtask

    task automatic rej(input int num);
        rej_valid = 1'b1; rej_num = 8'(num); @(negedge clk); rej_valid = 1'b0;
    endtask

    task automatic eoi(input int num);
        eoi_valid = 1'b1; eoi_num = 8'(num); @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic resend();
        resend_req = 1'b1; @(negedge clk); resend_req = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic exp_pres(input string tag, input int num, input int prio);
        chk({tag, " valid"}, pres_valid, 1);
        chk({tag, " num"}, pres_num, num);
        chk({tag, " prio"}, pres_prio, prio);
    endtask

    task automatic exp_none(input string tag);
        chk({tag, " idle"}, pres_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R12 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        exp_none("R1 reset");
        get_chk("R1 reset 16", 16, 0, 255);
        get_chk("R1 reset 23", 23, 0, 255);

        // R8 set and read back
        cfg(0, 16, 1, 5);
        chk("R8 ack", cfg_ack, 1);
        chk("R8 no err", cfg_err, 0);
        get_chk("R8 get 16", 16, 1, 5);

        // R10 parameter errors leave state alone
        cfg(0, 15, 1, 9); chk("R10 low num", cfg_err, 1);
        cfg(0, 24, 1, 9); chk("R10 high num", cfg_err, 1);
        cfg(0, 16, 4, 9); chk("R10 bad server", cfg_err, 1);
        cfg(1, 30, 0, 0); chk("R10 off bad num", cfg_err, 1);
        cfg(3, 8, 0, 0);  chk("R10 get bad num", cfg_err, 1);
        get_chk("R10 unchanged", 16, 1, 5);
        exp_none("R10 no offer");

        // R2 message event on an unmasked entry, held until accepted
        pulse(0);
        exp_pres("R2 msg", 16, 5);
        @(negedge clk);
        exp_pres("R2 msg held", 16, 5);
        take();
        exp_none("R2 after accept");

        // R3 masked message event is latched, then released by unmask
        pulse(1);
        exp_none("R3 masked event");
        cfg(0, 17, 0, 3);
        exp_pres("R3 unmask", 17, 3);
        take();
        exp_none("R3 consumed");

        // R9 disable and enable
        cfg(1, 16, 0, 0);
        get_chk("R9 off", 16, 1, 255);
        cfg(2, 16, 0, 0);
        get_chk("R9 on", 16, 1, 5);

        // R11 lowest index first
        cfg(0, 18, 0, 4);
        cfg(0, 19, 0, 1);
        src_in[2] = 1'b1; src_in[3] = 1'b1; @(negedge clk);
        src_in[2] = 1'b0; src_in[3] = 1'b0; @(negedge clk);
        exp_pres("R11 first", 18, 4);
        take();
        exp_pres("R11 second", 19, 1);
        take();
        exp_none("R11 drained");

        // R4 level present rule
        cfg(0, 20, 2, 7);
        src_in[4] = 1'b1; @(negedge clk);
        exp_pres("R4 level", 20, 7);
        take();
        repeat (3) @(negedge clk);
        exp_none("R4 sent blocks repeat");

        // R5 reject clears sent but waits for a sweep
        rej(20);
        repeat (2) @(negedge clk);
        exp_none("R5 no offer before sweep");
        resend();
        exp_pres("R7 level sweep", 20, 7);
        take();

        // R6 EOI clears sent on a level entry
        resend();
        exp_none("R6 sent still set");
        eoi(20);
        resend();
        exp_pres("R6 after eoi", 20, 7);
        take();

        // R13 masked asserted level entry offered on unmask
        src_in[5] = 1'b1; @(negedge clk);
        exp_none("R13 masked level");
        cfg(0, 21, 3, 2);
        exp_pres("R13 unmask", 21, 2);
        take();

        // R7 rejected message re-offered once by a sweep
        pulse(0); take();
        rej(16);
        resend();
        exp_pres("R7 msg resend", 16, 5);
        take();
        resend();
        exp_none("R7 no second resend");

        // R7 rejected message that is masked is dropped by the sweep
        pulse(0); take();
        rej(16);
        cfg(1, 16, 0, 0);
        resend();
        exp_none("R7 masked resend");
        cfg(2, 16, 0, 0);
        exp_none("R7 dropped after on");
        get_chk("R9 restored", 16, 1, 5);

        // R12 sweep stalls on a waiting request, then continues
        rej(20);
        pulse(0); take();
        rej(16);
        resend();
        exp_pres("R12 stall first", 16, 5);
        chk("R12 busy while stalled", scan_busy, 1);
        take();
        repeat (12) @(negedge clk);
        exp_pres("R12 resumed", 20, 7);
        take();
        exp_none("R12 done");

        // R4 deasserted level entry is not offered
        src_in[4] = 1'b0; @(negedge clk);
        eoi(20);
        resend();
        exp_none("R4 deasserted");

        // R8 R9 R10 random configuration traffic against a model
        pres_ready = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cfg(0, 16 + i, i % 4, 10 + i);
            m_srv[i] = i % 4; m_prio[i] = 10 + i; m_saved[i] = 10 + i;
        end
        for (int k = 0; k < 80; k++) begin
            int op, num, srv, prio, ix;
            bit bad;
            op = int'($urandom % 4);
            num = 14 + int'($urandom % 12);
            srv = int'($urandom % 6);
            prio = int'($urandom % 256);
            bad = exp_err(op, num, srv);
            cfg(op, num, srv, prio);
            chk("R10 random err", cfg_err, int'(bad));
            if (!bad) begin
                ix = num - 16;
                case (op)
                    0: begin m_srv[ix] = srv; m_prio[ix] = prio; m_saved[ix] = prio; end
                    1: begin m_saved[ix] = m_prio[ix]; m_prio[ix] = 255; end
                    2: m_prio[ix] = m_saved[ix];
                    default: begin
                        chk("R8 random prio", rd_prio, m_prio[ix]);
                        chk("R8 random server", rd_server, m_srv[ix]);
                    end
                endcase
            end
        end
        for (int i = 0; i < 8; i++) get_chk("R9 final sweep", 16 + i, m_srv[i], m_prio[i]);
        pres_ready = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule